// File: doc/BRIEF.md
# Fractional Ratio Cache Clock Divider

This block derives the clock for an external cache RAM interface from the core clock. A 3-bit ratio code selects one of five divide factors. Three are integers (1, 2, 3) and two are half-integers (1.5, 2.5). The half-integer factors need timing finer than one core period. To get it, the output is formed from a pair of toggle flops, one clocked on each core edge, and the two are combined with an XOR. Each flop decides its next level one core edge ahead, so the output only ever changes on a core edge and only one flop toggles per edge.

The output period is counted in core half-cycles. A ratio code, or a stop request from the power-management logic, is taken in only when a new output period is due to start. At that point the output is low, so a change never cuts a high phase short. The zero code and the two reserved codes hold the output low. The zero code also drops the enable sent to the downstream phase-alignment loop. A reserved code raises a flag. In the core clock domain, a one-cycle enable marks every core cycle in which the divided clock rises. A separate check compares the selected ratio against the system bus ratio and flags any setting where the cache clock would run slower than the bus.

Top module: `frac_clk_div`

## Requirements
- R1: While reset is asserted, and after it is released with code 000 applied, `clk_div_o`, `edge_en_o`, `illegal_code_o` and `loop_en_o` are all low.
- R2: Codes 001, 010, 100, 101 and 110 give an output period of 2, 3, 4, 5 and 6 core half-cycles, which is division by 1, 1.5, 2, 2.5 and 3.
- R3: In each output period, the output is high for the period length in half-cycles divided by two, rounded down. The rising edge starts the period.
- R4: `edge_en_o` is high for exactly those core cycles (posedge to posedge) in which `clk_div_o` rises. Over N core cycles it therefore pulses 2N/P times, where P is the period in half-cycles. With a ratio of 2 or more, it is never high for two cycles in a row.
- R5: Code 000 holds the output low with no enable pulses and drives `loop_en_o` low. Any of the five dividing codes drives `loop_en_o` high.
- R6: Reserved codes 011 and 111 hold the output low with no enable pulses and raise `illegal_code_o`. All other codes keep `illegal_code_o` low.
- R7: While `stop_i` is high, the output is held low with no enable pulses. After `stop_i` falls, the selected ratio resumes.
- R8: A new code or stop request is taken in only where an output period would begin, so every high pulse lasts exactly the high time of either the old ratio or the new one. A new input takes effect within 6 core cycles.
- R9: `cfg_err_o` is high, combinationally, exactly when the applied code is a dividing code whose period in half-cycles exceeds `bus_half_i`, the bus period in core half-cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ratio_i | input | 3 | Divide ratio code |
| stop_i | input | 1 | Low-power stop request |
| bus_half_i | input | BUS_W (4) | Bus clock period in core half-cycles |
| clk_div_o | output | 1 | Divided cache clock |
| edge_en_o | output | 1 | One-cycle marker of each divided-clock rising edge |
| illegal_code_o | output | 1 | Reserved ratio code in effect |
| loop_en_o | output | 1 | Enable for the downstream phase-alignment loop |
| cfg_err_o | output | 1 | Selected ratio slower than the bus clock |

## Verification
A phase counter that runs past the active period, or a ratio taken in at the wrong moment, shows at the divided clock within one output period. It appears either as a high pulse whose width fits neither ratio or as a wrong rising-edge count in the next measurement window. The enable and the divided clock come from the same registered decision, so the bench counts edges on both and compares them: an enable that slips by one cycle shifts the counts or breaks the one-cycle gap rule straight away. Stop and reserved codes are judged only at the output pins, after the boundary delay has passed.

// File: rtl/fcd_pkg.sv
`timescale 1ns/1ps
package fcd_pkg;

    localparam int SLOT_W = 3;

    typedef enum logic [2:0] {
        RC_HALT   = 3'd0,
        RC_BY1    = 3'd1,
        RC_BY1P5  = 3'd2,
        RC_RES_A  = 3'd3,
        RC_BY2    = 3'd4,
        RC_BY2P5  = 3'd5,
        RC_BY3    = 3'd6,
        RC_RES_B  = 3'd7
    } ratio_code_e;

    // Output period in core half-cycles; zero means no clock.
    function automatic logic [SLOT_W-1:0] period_slots(input logic [2:0] code);
        logic [SLOT_W-1:0] n;
        case (ratio_code_e'(code))
            RC_BY1:   n = SLOT_W'(2);
            RC_BY1P5: n = SLOT_W'(3);
            RC_BY2:   n = SLOT_W'(4);
            RC_BY2P5: n = SLOT_W'(5);
            RC_BY3:   n = SLOT_W'(6);
            default:  n = '0;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/fcd_ratio_decode.sv
`timescale 1ns/1ps
module fcd_ratio_decode #(
    parameter int SLOT_W = fcd_pkg::SLOT_W,
    parameter int BUS_W  = 4
) (
    input  logic [2:0]        code_i,
    input  logic [BUS_W-1:0]  bus_half_i,
    output logic [SLOT_W-1:0] slots_o,
    output logic              legal_o,
    output logic              rsvd_o,
    output logic              cfg_err_o
);
    always_comb begin
        slots_o   = fcd_pkg::period_slots(code_i);
        legal_o   = (slots_o != '0);
        rsvd_o    = (code_i == fcd_pkg::RC_RES_A) || (code_i == fcd_pkg::RC_RES_B);
        cfg_err_o = legal_o && (32'(slots_o) > 32'(bus_half_i));
    end
endmodule

// File: rtl/fcd_phase_seq.sv
`timescale 1ns/1ps
module fcd_phase_seq #(
    parameter int SLOT_W = fcd_pkg::SLOT_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [SLOT_W-1:0] slots_i,
    input  logic              legal_i,
    input  logic              rsvd_i,
    input  logic              stop_i,
    output logic              lvl_a_o,
    output logic              lvl_b_o,
    output logic              edge_en_o,
    output logic              loop_en_o,
    output logic              rsvd_o
);
    typedef struct packed {
        logic              run;
        logic              loop_en;
        logic              rsvd;
        logic [SLOT_W-1:0] per;
        logic [SLOT_W-1:0] ph;
        logic              en;
    } seq_t;

    seq_t seq_d, seq_q;

    logic [SLOT_W-1:0] per_use;
    logic [SLOT_W-1:0] high_len;
    logic [SLOT_W-1:0] ph_b;
    logic [SLOT_W-1:0] ph_n;
    logic              run_use;

    always_comb begin
        seq_d   = seq_q;
        per_use = seq_q.per;
        run_use = seq_q.run;
        lvl_a_o = 1'b0;
        lvl_b_o = 1'b0;
        ph_b    = '0;
        ph_n    = '0;

        // New settings enter only where a period would begin (output low).
        if (seq_q.ph == '0) begin
            run_use       = legal_i && !stop_i;
            per_use       = legal_i ? slots_i : '0;
            seq_d.loop_en = legal_i;
            seq_d.rsvd    = rsvd_i;
        end
        high_len = per_use >> 1;

        if (run_use) begin
            ph_b = seq_q.ph + SLOT_W'(1);
            if (ph_b >= per_use) ph_b = ph_b - per_use;
            ph_n = ph_b + SLOT_W'(1);
            if (ph_n >= per_use) ph_n = ph_n - per_use;
            lvl_a_o  = (seq_q.ph < high_len);
            lvl_b_o  = (ph_b < high_len);
            seq_d.en = (seq_q.ph == '0) || (ph_b == '0);
        end else begin
            seq_d.en = 1'b0;
        end
        seq_d.ph  = ph_n;
        seq_d.run = run_use;
        seq_d.per = per_use;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) seq_q <= '0;
        else         seq_q <= seq_d;
    end

    assign edge_en_o = seq_q.en;
    assign loop_en_o = seq_q.loop_en;
    assign rsvd_o    = seq_q.rsvd;

    p_off_no_edge_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !seq_q.loop_en |-> !seq_q.en);

    p_rsvd_no_edge_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        seq_q.rsvd |-> !seq_q.en);

    p_phase_in_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        seq_q.run |-> (seq_q.ph < seq_q.per));

    p_ratio_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seq_q.ph != '0) |=> $stable(seq_q.per));

    p_sparse_edge_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seq_q.en && (seq_q.per >= SLOT_W'(4))) |=> !seq_q.en);
endmodule

// File: rtl/fcd_edge_merge.sv
`timescale 1ns/1ps
module fcd_edge_merge (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic lvl_a_i,
    input  logic lvl_b_i,
    output logic clk_o
);
    typedef struct packed {
        logic tgl;
        logic lvl_b;
    } rise_t;

    rise_t rise_d, rise_q;
    logic  fall_d, fall_q;

    always_comb begin
        // Each flop picks the toggle that makes the XOR equal the wanted level.
        rise_d.tgl   = lvl_a_i ^ fall_q;
        rise_d.lvl_b = lvl_b_i;
        fall_d       = rise_q.lvl_b ^ rise_q.tgl;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) rise_q <= '0;
        else         rise_q <= rise_d;
    end

    always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) fall_q <= 1'b0;
        else         fall_q <= fall_d;
    end

    assign clk_o = rise_q.tgl ^ fall_q;
endmodule

// File: rtl/frac_clk_div.sv
`timescale 1ns/1ps
module frac_clk_div #(
    parameter int BUS_W  = 4,
    parameter int SLOT_W = fcd_pkg::SLOT_W
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [2:0]       ratio_i,
    input  logic             stop_i,
    input  logic [BUS_W-1:0] bus_half_i,
    output logic             clk_div_o,
    output logic             edge_en_o,
    output logic             illegal_code_o,
    output logic             loop_en_o,
    output logic             cfg_err_o
);
    logic [SLOT_W-1:0] slots;
    logic              legal;
    logic              rsvd;
    logic              lvl_a;
    logic              lvl_b;

    fcd_ratio_decode #(.SLOT_W(SLOT_W), .BUS_W(BUS_W)) u_decode (
        .code_i     (ratio_i),
        .bus_half_i (bus_half_i),
        .slots_o    (slots),
        .legal_o    (legal),
        .rsvd_o     (rsvd),
        .cfg_err_o  (cfg_err_o)
    );

    fcd_phase_seq #(.SLOT_W(SLOT_W)) u_seq (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .slots_i   (slots),
        .legal_i   (legal),
        .rsvd_i    (rsvd),
        .stop_i    (stop_i),
        .lvl_a_o   (lvl_a),
        .lvl_b_o   (lvl_b),
        .edge_en_o (edge_en_o),
        .loop_en_o (loop_en_o),
        .rsvd_o    (illegal_code_o)
    );

    fcd_edge_merge u_merge (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .lvl_a_i (lvl_a),
        .lvl_b_i (lvl_b),
        .clk_o   (clk_div_o)
    );
endmodule

// File: tb/frac_clk_div_tb.sv
`timescale 1ns/1ps
module frac_clk_div_tb;
    localparam int WIN = 60;

    typedef struct packed {
        logic [2:0] code;
        int         en_n;
        int         hi_n;
        logic       ill;
        logic       loop;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{3'b001, 60, 60, 1'b0, 1'b1},
        '{3'b010, 40, 40, 1'b0, 1'b1},
        '{3'b100, 30, 60, 1'b0, 1'b1},
        '{3'b101, 24, 48, 1'b0, 1'b1},
        '{3'b110, 20, 60, 1'b0, 1'b1},
        '{3'b000,  0,  0, 1'b0, 1'b0},
        '{3'b011,  0,  0, 1'b1, 1'b0},
        '{3'b111,  0,  0, 1'b1, 1'b0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] ratio = 3'b000;
    logic       stop = 1'b0;
    logic [3:0] bus_half = 4'd6;
    logic       clk_div, edge_en, illegal, loop_en, cfg_err;

    int checks = 0;
    int errors = 0;
    int rise_cnt = 0;
    int h_old = 0;
    int h_new = 0;
    time t_rise = 0;
    int en_seen, hi_seen, rise_seen, back2back;

    always #10 clk = ~clk;

    frac_clk_div u_dut (
        .clk_i(clk), .rst_ni(rst_n), .ratio_i(ratio), .stop_i(stop),
        .bus_half_i(bus_half), .clk_div_o(clk_div), .edge_en_o(edge_en),
        .illegal_code_o(illegal), .loop_en_o(loop_en), .cfg_err_o(cfg_err)
    );

    function automatic int high_of(input logic [2:0] c);
        case (c)
            3'b001, 3'b010: return 1;
            3'b100, 3'b101: return 2;
            3'b110:         return 3;
            default:        return 0;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // R3 and R8: each high pulse must match the old or the new ratio's high time.
    always @(posedge clk_div) begin
        rise_cnt++;
        t_rise = $time;
    end
    always @(negedge clk_div) begin
        if (rst_n) begin
            int w;
            w = int'($time - t_rise);
            chk((w == 10 * h_old) || (w == 10 * h_new), "R8 high pulse width ns", w, 10 * h_new);
        end
    end

    task automatic measure(input int cycles);
        int r0;
        logic prev_en;
        en_seen = 0; hi_seen = 0; back2back = 0; prev_en = 1'b0;
        @(posedge clk); #2;
        r0 = rise_cnt;
        for (int i = 0; i < cycles; i++) begin
            #3;
            if (edge_en) en_seen++;
            if (edge_en && prev_en) back2back++;
            prev_en = edge_en;
            if (clk_div) hi_seen++;
            #10;
            if (clk_div) hi_seen++;
            #7;
        end
        rise_seen = rise_cnt - r0;
    endtask

    task automatic set_code(input logic [2:0] c);
        @(posedge clk); #12;
        h_old = h_new > high_of(c) ? h_new : high_of(c);
        h_old = h_new;
        h_new = high_of(c);
        ratio = c;
        repeat (8) @(posedge clk);
        h_old = h_new;
    endtask

    initial begin
        #(20 * 100000);
        chk(1'b0, "watchdog", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state, with a dividing code applied during reset
        ratio = 3'b100;
        repeat (3) @(posedge clk);
        #5;
        chk(clk_div == 1'b0, "R1 clk_div in reset", int'(clk_div), 0);
        chk(edge_en == 1'b0, "R1 edge_en in reset", int'(edge_en), 0);
        chk(loop_en == 1'b0, "R1 loop_en in reset", int'(loop_en), 0);
        ratio = 3'b000;
        #10 rst_n = 1'b1;
        measure(10);
        chk(hi_seen == 0, "R1 output low after reset", hi_seen, 0);
        chk(en_seen == 0, "R1 no edges after reset", en_seen, 0);
        chk(illegal == 1'b0, "R1 illegal low", int'(illegal), 0);
        chk(loop_en == 1'b0, "R1 loop_en low", int'(loop_en), 0);

        // Table walk: R2 R3 R4 R5 R6 R9
        for (int k = 0; k < 8; k++) begin
            set_code(VECS[k].code);
            measure(WIN);
            chk(en_seen == VECS[k].en_n, "R4 enable pulses per window", en_seen, VECS[k].en_n);
            chk(rise_seen == VECS[k].en_n, "R2 rising edges per window", rise_seen, VECS[k].en_n);
            chk(hi_seen == VECS[k].hi_n, "R3 high half-cycles per window", hi_seen, VECS[k].hi_n);
            chk(illegal == VECS[k].ill, "R6 illegal flag", int'(illegal), int'(VECS[k].ill));
            chk(loop_en == VECS[k].loop, "R5 loop enable", int'(loop_en), int'(VECS[k].loop));
            chk(cfg_err == 1'b0, "R9 no error with slow bus", int'(cfg_err), 0);
            if (high_of(VECS[k].code) >= 2)
                chk(back2back == 0, "R4 enable never two cycles running", back2back, 0);
        end

        // R7: stop request
        set_code(3'b100);
        @(posedge clk); #12 stop = 1'b1;
        repeat (8) @(posedge clk);
        measure(20);
        chk(hi_seen == 0, "R7 output low while stopped", hi_seen, 0);
        chk(en_seen == 0, "R7 no enables while stopped", en_seen, 0);
        chk(loop_en == 1'b1, "R7 loop stays enabled", int'(loop_en), 1);
        @(posedge clk); #12 stop = 1'b0;
        repeat (8) @(posedge clk);
        measure(20);
        chk(en_seen == 10, "R7 resume enables", en_seen, 10);
        chk(hi_seen == 20, "R7 resume high time", hi_seen, 20);

        // R8: switches at several offsets; width monitor judges each pulse
        for (int off = 0; off < 5; off++) begin
            set_code(3'b110);
            repeat (off) @(posedge clk);
            set_code(3'b001);
            repeat (off) @(posedge clk);
            set_code(3'b101);
            set_code(3'b010);
        end
        measure(30);
        chk(en_seen == 20, "R8 settled after switching", en_seen, 20);

        // R9: configuration error against a faster bus
        bus_half = 4'd4;
        ratio = 3'b101; #1;
        chk(cfg_err == 1'b1, "R9 2.5 vs bus 4", int'(cfg_err), 1);
        ratio = 3'b110; #1;
        chk(cfg_err == 1'b1, "R9 3 vs bus 4", int'(cfg_err), 1);
        ratio = 3'b100; #1;
        chk(cfg_err == 1'b0, "R9 2 vs bus 4", int'(cfg_err), 0);
        ratio = 3'b000; #1;
        chk(cfg_err == 1'b0, "R9 halt code", int'(cfg_err), 0);
        ratio = 3'b111; #1;
        chk(cfg_err == 1'b0, "R9 reserved code", int'(cfg_err), 0);
        ratio = 3'b010;

        repeat (10) @(posedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule